// File: doc/BRIEF.md
# Fractional Square-Wave Time-Pulse Generator

This block turns a fixed system clock (48 MHz by default) into a square wave at any integer frequency from 1 Hz up to 10 MHz. A phase accumulator adds twice the programmed frequency on every enabled clock, modulo the clock rate. Each time the accumulator rolls over, the output level flips.

When the clock rate is not an exact multiple of twice the frequency, the half-period lengths alternate between the two nearest whole clock counts. The average frequency is still exact over the long run. A single-cycle slip input holds the phase still for one clock, which lets a controller drop a tick to pull back accumulated time error.

A frequency value is copied in only when the load strobe is high. The load restarts the waveform from a known phase. A separate wrap flag marks every edge of the output.

Top module: `nco_timepulse`

## Requirements
- R1: While reset is asserted and after it is released, both `pulse_o` and `wrap_o` are low until a valid frequency has been loaded and the first rollover happens.
- R2: Count the enabled, non-slipped clocks after the load edge. The n-th output toggle happens on the clock where this count reaches ceil(n·CLK_HZ / (2·f)), where f is the loaded frequency.
- R3: Every half-period lasts either floor or ceil of CLK_HZ / (2·f) clocks. No two rollovers happen on adjacent clocks.
- R4: When 2·f divides CLK_HZ exactly, every half-period has the same length. For example, 1 MHz gives 24 clocks per half-period.
- R5: At 10 MHz, every half-period is 2 or 3 clocks long, and any 10 consecutive half-periods starting at the load total exactly 24 clocks.
- R6: `wrap_o` is high for exactly one clock on every toggle of `pulse_o`, and `pulse_o` changes at no other time except a load.
- R7: A clock on which `slip_i` is high advances neither the phase nor the output. All later edges move one clock later.
- R8: A clock on which `en_i` is low freezes the phase and the output in the same way.
- R9: A load clears the phase and drives `pulse_o` low on the next clock. A change on `word_i` without a load has no effect.
- R10: A loaded value of 0, or any value above MAX_HZ (10,000,000), is rejected. The output then stays low and no wrap is flagged until a valid load arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Phase advance enable |
| slip_i | input | 1 | Drop-one-tick request, one clock wide |
| load_i | input | 1 | Frequency load strobe |
| word_i | input | FW_W (24) | Requested frequency in Hz |
| pulse_o | output | 1 | Square-wave time pulse |
| wrap_o | output | 1 | One-clock flag on each output toggle |

## Verification
The checker assumes three things about the inputs: they are synchronous to the clock, `slip_i` and `en_i` are not used as a substitute for load, and the loaded frequency never exceeds MAX_HZ. The last point means a rollover can never follow a rollover on the very next clock. The stimulus changes every input once per cycle, just after the active edge. It holds `slip_i` high for a single clock only. It pauses the phase only with `en_i`, and it offers out-of-range words solely to exercise rejection. Expected edge positions are derived from the ceiling formula of R2. The clocks lost to slip and enable are added explicitly.

// File: rtl/nco_tp_pkg.sv
package nco_tp_pkg;
    localparam int unsigned DEF_CLK_HZ = 48_000_000;
    localparam int unsigned DEF_MAX_HZ = 10_000_000;
    localparam int unsigned DEF_FW_W   = 24;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP
    } nco_act_e;
endpackage

// File: rtl/nco_tp_wordcheck.sv
module nco_tp_wordcheck #(
    parameter int unsigned FW_W   = 24,
    parameter int unsigned MAX_HZ = 10_000_000
) (
    input  logic [FW_W-1:0] word_i,
    output logic            ok_o
);
    localparam logic [FW_W:0] LIMIT = (FW_W+1)'(MAX_HZ);

    always_comb begin
        ok_o = (word_i != '0) && ({1'b0, word_i} <= LIMIT);
    end
endmodule

// File: rtl/nco_tp_phase.sv
module nco_tp_phase #(
    parameter int unsigned ACC_W  = 26,
    parameter int unsigned FW_W   = 24,
    parameter int unsigned CLK_HZ = 48_000_000
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [FW_W-1:0]  freq_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             roll_o
);
    localparam int unsigned SUM_W = ((ACC_W > FW_W + 1) ? ACC_W : FW_W + 1) + 1;
    localparam logic [SUM_W-1:0] MODULUS = SUM_W'(CLK_HZ);

    logic [SUM_W-1:0] incr;
    logic [SUM_W-1:0] sum;

    always_comb begin
        incr   = SUM_W'({freq_i, 1'b0});
        sum    = SUM_W'(acc_i) + incr;
        roll_o = (sum >= MODULUS);
        acc_o  = roll_o ? ACC_W'(sum - MODULUS) : ACC_W'(sum);
    end
endmodule

// File: rtl/nco_timepulse.sv
module nco_timepulse
    import nco_tp_pkg::*;
#(
    parameter int unsigned CLK_HZ = DEF_CLK_HZ,
    parameter int unsigned MAX_HZ = DEF_MAX_HZ,
    parameter int unsigned FW_W   = DEF_FW_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic            slip_i,
    input  logic            load_i,
    input  logic [FW_W-1:0] word_i,
    output logic            pulse_o,
    output logic            wrap_o
);
    localparam int unsigned ACC_W = $clog2(CLK_HZ);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [FW_W-1:0]  freq;
        logic             valid;
        logic             pulse;
        logic             wrap;
    } nco_state_t;

    nco_state_t st_d, st_q;
    nco_act_e   act;
    logic             word_ok;
    logic [ACC_W-1:0] acc_next;
    logic             roll;

    nco_tp_wordcheck #(.FW_W(FW_W), .MAX_HZ(MAX_HZ)) u_check (
        .word_i (word_i),
        .ok_o   (word_ok)
    );

    nco_tp_phase #(.ACC_W(ACC_W), .FW_W(FW_W), .CLK_HZ(CLK_HZ)) u_phase (
        .acc_i  (st_q.acc),
        .freq_i (st_q.freq),
        .acc_o  (acc_next),
        .roll_o (roll)
    );

    always_comb begin
        if (load_i)                            act = ACT_LOAD;
        else if (st_q.valid && en_i && !slip_i) act = ACT_STEP;
        else                                   act = ACT_HOLD;

        st_d      = st_q;
        st_d.wrap = 1'b0;
        case (act)
            ACT_LOAD: begin
                st_d.freq  = word_i;
                st_d.valid = word_ok;
                st_d.acc   = '0;
                st_d.pulse = 1'b0;
            end
            ACT_STEP: begin
                st_d.acc = acc_next;
                if (roll) begin
                    st_d.pulse = ~st_q.pulse;
                    st_d.wrap  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign wrap_o  = st_q.wrap;
endmodule

// File: rtl/nco_tp_chk.sv
module nco_tp_chk #(
    parameter int unsigned FW_W   = 24,
    parameter int unsigned MAX_HZ = 10_000_000
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            en_i,
    input logic            slip_i,
    input logic            load_i,
    input logic [FW_W-1:0] word_i,
    input logic            pulse_o,
    input logic            wrap_o
);
    logic bad_word;
    assign bad_word = (word_i == '0) || ({1'b0, word_i} > (FW_W+1)'(MAX_HZ));

    // R6: every wrap flag coincides with a level change
    a_r6_wrap_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> (pulse_o != $past(pulse_o)));

    // R3: with MAX_HZ below a quarter of the clock, rollovers never abut
    a_r3_no_adjacent_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> !wrap_o);

    // R9: a load restarts from low phase
    a_r9_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (!pulse_o && !wrap_o));

    // R10: a rejected word yields a low, silent output
    a_r10_reject_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && bad_word) |=> (!pulse_o && !wrap_o));

    // R7: a slipped clock leaves the output untouched
    a_r7_slip_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_i && !load_i) |=> (!wrap_o && $stable(pulse_o)));

    // R8: a disabled clock leaves the output untouched
    a_r8_disable_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load_i) |=> (!wrap_o && $stable(pulse_o)));
endmodule

bind nco_timepulse nco_tp_chk #(.FW_W(FW_W), .MAX_HZ(MAX_HZ)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .slip_i  (slip_i),
    .load_i  (load_i),
    .word_i  (word_i),
    .pulse_o (pulse_o),
    .wrap_o  (wrap_o)
);

// File: tb/tb_nco_timepulse.sv
module tb_nco_timepulse;
    localparam longint CLK_HZ = 48_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        slip = 1'b0;
    logic        load = 1'b0;
    logic [23:0] word = '0;
    logic        pulse;
    logic        wrap;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    int meas[$];
    int since = 0;
    bit lvl = 1'b0;
    bit strict = 1'b0;

    always #4 clk = ~clk;

    nco_timepulse dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .slip_i(slip),
        .load_i(load), .word_i(word), .pulse_o(pulse), .wrap_o(wrap)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: measures half-periods and compares with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (load) begin
                since = -1;
                lvl   = 1'b0;
            end else begin
                since++;
                if (strict) begin
                    check(!wrap && !pulse, "R10 silent output", {pulse, wrap}, 0);
                end else if (wrap && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    meas.push_back(since);
                    check(since == e, "R2 half-period length", since, e);
                    lvl = ~lvl;
                    check(pulse == lvl, "R6 level after wrap", pulse, lvl);
                end
                if (wrap) since = 0;
            end
        end
    end

    // driver: computes expected edges, loads the word, applies slip/enable
    task automatic run(input int f, input int n, input int slip_at,
                       input int off_at, input int off_len,
                       input int chg_at, input int chg_word);
        longint steps = 0;
        int prev = 0;
        int k = 1;
        int j = 1;
        meas.delete();
        while (k <= n) begin
            bit blocked;
            longint tgt;
            blocked = (j == slip_at) || (j >= off_at && j < off_at + off_len);
            tgt = (longint'(k) * CLK_HZ + 2 * f - 1) / (2 * f);
            if (!blocked) begin
                steps++;
                if (steps == tgt) begin
                    exp_q.push_back(j - prev);
                    prev = j;
                    k++;
                end
            end
            j++;
        end
        @(posedge clk); #1;
        word = f[23:0]; load = 1'b1; en = 1'b1; slip = 1'b0;
        @(posedge clk); #1;
        load = 1'b0;
        check(pulse == 1'b0 && wrap == 1'b0, "R9 cleared after load", {pulse, wrap}, 0);
        for (int c = 1; c < 5000 && exp_q.size() > 0; c++) begin
            slip = (c == slip_at);
            en   = !(c >= off_at && c < off_at + off_len);
            if (c == chg_at) word = chg_word[23:0];
            @(posedge clk); #1;
        end
        slip = 1'b0; en = 1'b1;
        check(exp_q.size() == 0, "R2 all edges seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic reject(input int w);
        @(posedge clk); #1;
        word = w[23:0]; load = 1'b1;
        @(posedge clk); #1;
        load = 1'b0;
        strict = 1'b1;
        repeat (60) @(posedge clk);
        #1 strict = 1'b0;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int sum;
        bit ok;
        repeat (3) @(negedge clk);
        check(pulse == 0 && wrap == 0, "R1 during reset", {pulse, wrap}, 0);
        #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(pulse == 0 && wrap == 0, "R1 idle after reset", {pulse, wrap}, 0);

        // R5: 10 MHz, 2/3 dithering, 24 clocks per 10 halves
        run(10_000_000, 20, 0, 0, 0, 0, 0);
        sum = 0; ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sum += meas[i];
            if (meas[i] != 2 && meas[i] != 3) ok = 1'b0;
        end
        check(sum == 24, "R5 ten halves total", sum, 24);
        check(ok, "R5 halves are 2 or 3", ok, 1);

        // R4: 1 MHz, no dithering
        run(1_000_000, 6, 0, 0, 0, 0, 0);
        ok = 1'b1;
        foreach (meas[i]) if (meas[i] != 24) ok = 1'b0;
        check(ok, "R4 constant 24-clock halves", ok, 1);

        // R3: irregular ratio, halves within floor/ceil
        run(2_900_000, 30, 0, 0, 0, 0, 0);
        ok = 1'b1;
        foreach (meas[i]) if (meas[i] != 8 && meas[i] != 9) ok = 1'b0;
        check(ok, "R3 halves 8 or 9", ok, 1);

        // R7: slip at clock 30 of a 1 MHz wave stretches the second half
        run(1_000_000, 4, 30, 0, 0, 0, 0);
        check(meas[1] == 25, "R7 slipped half", meas[1], 25);

        // R8: enable low for 5 clocks
        run(10_000_000, 12, 0, 7, 5, 0, 0);

        // R9: word change without load is ignored
        run(10_000_000, 16, 0, 0, 0, 4, 3_000_000);

        // R10: rejected words, including just above the limit
        reject(0);
        reject(10_000_001);
        check(pulse == 0, "R10 low after reject", pulse, 0);

        // R2: recovery with a small odd frequency after rejection
        run(777_777, 6, 0, 0, 0, 0, 0);
        summary();
    end
endmodule